// File: doc/BRIEF.md
# Compare Channel Pulse Generator Bank

This block holds a set of compare channels that watch the running value of a time counter. Each channel is armed with a compare value. When the counter reaches that value, the channel records an event. Depending on its mode, the channel also toggles its output pin or drives it high for one clock. A periodic output such as a one-pulse-per-second strobe or a square wave can run without gaps, because each channel holds a second compare value in reserve. Software loads the match after next while the current match is still waiting. When the current match fires, the reserve value becomes the active one.

Software reaches each channel through two 32-bit registers on a simple write/read port: a control word and a compare word. The interrupt line is asserted while any channel has both its event flag and its interrupt enable set. Compare values are taken modulo the time-base width, which is 31 bits by default.

Top module: `tcmp_bank`

## Requirements
- R1: After reset, every register reads zero, every output pin is low and the interrupt output is low.
- R2: In the control word, bit 0 is a stored DMA enable, bits 5:2 are the mode code, bit 6 is the interrupt enable and bit 7 is the event flag. Bit 1 and bits 31:8 read as zero.
- R3: A compare write made while the channel's mode code is zero becomes the active match. Reading the compare word returns the active compare value.
- R4: A channel with a nonzero mode and an armed match sets its event flag at the first clock edge where the time count equals the active compare value.
- R5: In mode code 0x5, the output pin inverts at each match.
- R6: In mode code 0xF, the output pin is high for exactly the one clock cycle that follows each match and low otherwise.
- R7: A compare write made while the mode is nonzero is queued, and becomes the active match when the current one fires. If nothing is queued, the channel fires once and then stays idle until it is armed again.
- R8: Writing 1 to bit 7 clears the event flag, and writing 0 to bit 7 leaves it unchanged. A match in the same cycle as a clearing write leaves the flag set.
- R9: The interrupt output is high while any channel has both its event flag and its interrupt enable set.
- R10: Writing a zero mode code disables the channel. Its output goes low, the active and queued matches are discarded, and the channel fires no more events until it is armed again.
- R11: Channel n has its control word at 0x608+8n and its compare word at 0x60C+8n, for n = 0 to 3. Writes to other addresses have no effect, and reads of other addresses return zero. Channels operate independently.
- R12: Compare values are used modulo 2^31: bit 31 of a compare write is dropped, and a match at count 0x7FFFFFFF fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock for the counter and the registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_cnt | input | 31 | Live value of the time counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 12 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| ch_out | output | 4 | Per-channel output pins |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: four channels, a 31-bit time base, a 32-bit data bus and a 12-bit address. Four channels put the whole address window within reach, together with the addresses just below and just above it, so decode misses and cross-channel independence can both be observed. The bench drives the time count directly instead of counting up to it. Matches near the top of the 31-bit range, such as 0x7FFFFFFF, can therefore be hit in a few cycles.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
   localparam logic [3:0] MODE_OFF    = 4'h0;
   localparam logic [3:0] MODE_TOGGLE = 4'h5;
   localparam logic [3:0] MODE_PULSE  = 4'hF;
   localparam int BIT_DMA  = 0;
   localparam int BIT_MLO  = 2;
   localparam int BIT_MHI  = 5;
   localparam int BIT_IE   = 6;
   localparam int BIT_FLAG = 7;
endpackage

// File: rtl/tcmp_regdec.sv
module tcmp_regdec #(
   parameter int NCH  = 4,
   parameter int AW   = 12,
   parameter logic [AW-1:0] BASE = 12'h608
) (
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [AW-1:0] rd_addr,
   output logic [NCH-1:0] ctrl_we,
   output logic [NCH-1:0] cmp_we,
   output logic           rd_hit,
   output logic           rd_is_cmp,
   output logic [(NCH>1 ? $clog2(NCH) : 1)-1:0] rd_ch
);
   localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1;
   localparam int SPAN = NCH * 8;

   logic [AW-1:0] w_off, r_off;
   logic          w_in, r_in;

   assign w_off = wr_addr - BASE;
   assign r_off = rd_addr - BASE;
   assign w_in  = (wr_addr >= BASE) && (int'(w_off) < SPAN) && (w_off[1:0] == 2'b00);
   assign r_in  = (rd_addr >= BASE) && (int'(r_off) < SPAN) && (r_off[1:0] == 2'b00);

   for (genvar i = 0; i < NCH; i++) begin : g_dec
      assign ctrl_we[i] = wr_en && w_in && (int'(w_off[AW-1:3]) == i) && !w_off[2];
      assign cmp_we[i]  = wr_en && w_in && (int'(w_off[AW-1:3]) == i) &&  w_off[2];
   end

   assign rd_hit    = r_in;
   assign rd_is_cmp = r_off[2];
   assign rd_ch     = r_off[CW+2:3];
endmodule

// File: rtl/tcmp_chan.sv
module tcmp_chan
   import tcmp_pkg::*;
#(
   parameter int TW = 31
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] tcnt,
   input  logic          ctrl_we,
   input  logic          cmp_we,
   input  logic [7:0]    ctrl_wd,
   input  logic [TW-1:0] cmp_wd,
   output logic [7:0]    ctrl_rd,
   output logic [TW-1:0] cmp_rd,
   output logic          hit,
   output logic          flag,
   output logic          ie,
   output logic [3:0]    mode,
   output logic          pin
);
   logic          dma_q;
   logic [TW-1:0] cur_q, nxt_q;
   logic          cur_v, nxt_v;
   logic          active, off_wr;
   logic          unused_b1;

   assign unused_b1 = ctrl_wd[1];
   assign active    = (mode != MODE_OFF);
   assign hit       = active && cur_v && (tcnt == cur_q);
   assign off_wr    = ctrl_we && (ctrl_wd[BIT_MHI:BIT_MLO] == MODE_OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dma_q <= 1'b0;
         mode  <= MODE_OFF;
         ie    <= 1'b0;
         flag  <= 1'b0;
         pin   <= 1'b0;
         cur_q <= '0;
         nxt_q <= '0;
         cur_v <= 1'b0;
         nxt_v <= 1'b0;
      end else begin
         if (ctrl_we) begin
            dma_q <= ctrl_wd[BIT_DMA];
            mode  <= ctrl_wd[BIT_MHI:BIT_MLO];
            ie    <= ctrl_wd[BIT_IE];
         end
         // event flag: a match outranks a clearing write
         if (hit)
            flag <= 1'b1;
         else if (ctrl_we && ctrl_wd[BIT_FLAG])
            flag <= 1'b0;
         // output pin
         if (off_wr)
            pin <= 1'b0;
         else if (mode == MODE_TOGGLE) begin
            if (hit) pin <= ~pin;
         end else if (mode == MODE_PULSE)
            pin <= hit;
         else
            pin <= 1'b0;
         // double-buffered compare
         if (hit) begin
            if (nxt_v) begin
               cur_q <= nxt_q;
               nxt_v <= 1'b0;
            end else
               cur_v <= 1'b0;
         end
         if (cmp_we) begin
            if (!active) begin
               cur_q <= cmp_wd;
               cur_v <= 1'b1;
            end else begin
               nxt_q <= cmp_wd;
               nxt_v <= 1'b1;
            end
         end
         if (off_wr) begin
            cur_v <= 1'b0;
            nxt_v <= 1'b0;
         end
      end
   end

   assign ctrl_rd = {flag, ie, mode, 1'b0, dma_q};
   assign cmp_rd  = cur_q;
endmodule

// File: rtl/tcmp_bank.sv
module tcmp_bank #(
   parameter int NCH = 4,
   parameter int TW  = 31,
   parameter int DW  = 32,
   parameter int AW  = 12,
   parameter logic [AW-1:0] BASE = 12'h608
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] time_cnt,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   output logic [NCH-1:0] ch_out,
   output logic          irq
);
   localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

   if (NCH < 1 || NCH > 64) begin : g_bad_nch
      $error("tcmp_bank: NCH out of range");
   end
   if (TW < 2 || TW > DW) begin : g_bad_tw
      $error("tcmp_bank: TW must lie in 2..DW");
   end
   if (DW < 8) begin : g_bad_dw
      $error("tcmp_bank: DW must be at least 8");
   end

   logic [NCH-1:0]          ctrl_we, cmp_we;
   logic                    rd_hit, rd_is_cmp;
   logic [CW-1:0]           rd_ch;
   logic [NCH-1:0][7:0]     ctrl_rd;
   logic [NCH-1:0][TW-1:0]  cmp_rd;
   logic [NCH-1:0][3:0]     ch_mode;
   logic [NCH-1:0]          ch_hit, ch_flag, ch_ie;

   if (TW < DW) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^wr_data[DW-1:TW];
   end

   tcmp_regdec #(.NCH(NCH), .AW(AW), .BASE(BASE)) u_dec (
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .rd_addr  (rd_addr),
      .ctrl_we  (ctrl_we),
      .cmp_we   (cmp_we),
      .rd_hit   (rd_hit),
      .rd_is_cmp(rd_is_cmp),
      .rd_ch    (rd_ch)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      tcmp_chan #(.TW(TW)) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .tcnt   (time_cnt),
         .ctrl_we(ctrl_we[i]),
         .cmp_we (cmp_we[i]),
         .ctrl_wd(wr_data[7:0]),
         .cmp_wd (wr_data[TW-1:0]),
         .ctrl_rd(ctrl_rd[i]),
         .cmp_rd (cmp_rd[i]),
         .hit    (ch_hit[i]),
         .flag   (ch_flag[i]),
         .ie     (ch_ie[i]),
         .mode   (ch_mode[i]),
         .pin    (ch_out[i])
      );
   end

   assign irq = |(ch_flag & ch_ie);

   always_comb begin
      rd_data = '0;
      if (rd_hit) begin
         if (rd_is_cmp) rd_data = DW'(cmp_rd[rd_ch]);
         else           rd_data = DW'(ctrl_rd[rd_ch]);
      end
   end
endmodule

// File: rtl/tcmp_bank_chk.sv
module tcmp_bank_chk
   import tcmp_pkg::*;
#(
   parameter int NCH = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NCH-1:0]      hit,
   input logic [NCH-1:0]      flag,
   input logic [NCH-1:0][3:0] mode,
   input logic [NCH-1:0]      out
);
   for (genvar i = 0; i < NCH; i++) begin : g_a
      // R4
      flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         hit[i] |=> flag[i]);
      // R5
      toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (hit[i] && mode[i] == MODE_TOGGLE) |=> (out[i] != $past(out[i])));
      // R6
      pulse_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (hit[i] && mode[i] == MODE_PULSE) |=> out[i]);
      // R6
      pulse_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!hit[i] && mode[i] == MODE_PULSE) |=> !out[i]);
      // R10
      off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (mode[i] == MODE_OFF) |-> (!out[i] && !hit[i]));
   end
endmodule

bind tcmp_bank tcmp_bank_chk #(.NCH(NCH)) u_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .hit  (ch_hit),
   .flag (ch_flag),
   .mode (ch_mode),
   .out  (ch_out)
);

// File: tb/test_tcmp_bank.sv
module test_tcmp_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [30:0] time_cnt = '0;
   logic        wr_en = 1'b0;
   logic [11:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [11:0] rd_addr = '0;
   logic [31:0] rd_data;
   logic [3:0]  ch_out;
   logic        irq;
   int          n_run = 0;
   int          n_fail = 0;

   always #10 clk = ~clk;

   tcmp_bank i_tcmp_bank (
      .clk(clk), .rst_n(rst_n), .time_cnt(time_cnt),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .ch_out(ch_out), .irq(irq)
   );

   // {write addr, write data, read addr, expected read}
   localparam logic [87:0] VEC [8] = '{
      {12'h608, 32'h0000_005D, 12'h608, 32'h0000_005D}, // R2 all fields
      {12'h608, 32'hFFFF_FF02, 12'h608, 32'h0000_0000}, // R2 bit1/high bits read 0
      {12'h60C, 32'h8000_0123, 12'h60C, 32'h0000_0123}, // R3 R12 bit31 dropped
      {12'h614, 32'h7FFF_FFFF, 12'h614, 32'h7FFF_FFFF}, // R11 ch1 compare
      {12'h618, 32'h0000_0054, 12'h618, 32'h0000_0054}, // R11 ch2 control
      {12'h620, 32'h0000_003C, 12'h620, 32'h0000_003C}, // R11 ch3 control
      {12'h600, 32'h0000_00FF, 12'h600, 32'h0000_0000}, // R11 below window
      {12'h628, 32'h0000_0001, 12'h628, 32'h0000_0000}  // R11 above window
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
      rd_addr = a;
      #1;
      check(req, rd_data, exp);
   endtask

   task automatic set_t(input logic [30:0] v);
      @(negedge clk);
      time_cnt = v;
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      time_cnt = '0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(100000 * 20);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state
      for (int c = 0; c < 4; c++) begin
         rd_chk("R1 ctrl", 12'(12'h608 + 8 * c), 32'h0);
         rd_chk("R1 cmp",  12'(12'h60C + 8 * c), 32'h0);
      end
      check("R1 pins", {28'h0, ch_out}, 32'h0);
      check("R1 irq", {31'h0, irq}, 32'h0);

      // register vectors
      for (int k = 0; k < 8; k++) begin
         wr(VEC[k][87:76], VEC[k][75:44]);
         rd_chk("R2/R3/R11/R12 vector", VEC[k][43:32], VEC[k][31:0]);
      end

      do_reset();
      // toggle channel 0 with queued compare
      wr(12'h60C, 32'd100);
      wr(12'h608, 32'h54);
      wr(12'h60C, 32'd200);
      rd_chk("R7 queued not active", 12'h60C, 32'd100);
      set_t(31'd99);
      check("R4 no early match", {28'h0, ch_out}, 32'h0);
      set_t(31'd100);
      check("R5 toggle high", {31'h0, ch_out[0]}, 32'h1);
      rd_chk("R4 flag set", 12'h608, 32'hD4);
      check("R9 irq on", {31'h0, irq}, 32'h1);
      rd_chk("R7 queued promoted", 12'h60C, 32'd200);
      wr(12'h608, 32'hD4);
      rd_chk("R8 w1c clears", 12'h608, 32'h54);
      check("R9 irq off", {31'h0, irq}, 32'h0);
      wr(12'h608, 32'h54);
      rd_chk("R8 write zero keeps", 12'h608, 32'h54);
      set_t(31'd200);
      check("R5 toggle low", {31'h0, ch_out[0]}, 32'h0);
      set_t(31'd201);
      wr(12'h608, 32'hD4);
      set_t(31'd200);
      rd_chk("R7 fires once", 12'h608, 32'h54);
      check("R7 pin holds", {31'h0, ch_out[0]}, 32'h0);

      // pulse channel 3, interrupt disabled
      wr(12'h624, 32'd50);
      wr(12'h620, 32'h3C);
      wr(12'h624, 32'd60);
      set_t(31'd50);
      check("R6 pulse high", {31'h0, ch_out[3]}, 32'h1);
      check("R9 no irq without enable", {31'h0, irq}, 32'h0);
      set_t(31'd51);
      check("R6 pulse one cycle", {31'h0, ch_out[3]}, 32'h0);
      set_t(31'd60);
      check("R6 second pulse", {31'h0, ch_out[3]}, 32'h1);
      set_t(31'd61);
      check("R6 second pulse ends", {31'h0, ch_out[3]}, 32'h0);

      // channel 1: match and clear in one cycle
      wr(12'h614, 32'd10);
      wr(12'h610, 32'h54);
      @(negedge clk);
      time_cnt = 31'd10;
      wr_en = 1'b1; wr_addr = 12'h610; wr_data = 32'hD4;
      @(negedge clk);
      wr_en = 1'b0;
      rd_chk("R8 set beats clear", 12'h610, 32'hD4);
      check("R11 only ch1 pin", {28'h0, ch_out}, 32'h2);

      // channel 2: disable discards matches
      wr(12'h61C, 32'd5);
      wr(12'h618, 32'h54);
      wr(12'h61C, 32'd6);
      set_t(31'd5);
      check("R10 armed pin", {31'h0, ch_out[2]}, 32'h1);
      wr(12'h618, 32'h0);
      check("R10 pin low", {31'h0, ch_out[2]}, 32'h0);
      rd_chk("R10 mode zero flag kept", 12'h618, 32'h80);
      wr(12'h618, 32'h80);
      wr(12'h618, 32'h14);
      set_t(31'd6);
      check("R10 no event", {31'h0, ch_out[2]}, 32'h0);
      rd_chk("R10 no flag", 12'h618, 32'h14);

      // wrap point of the time base
      do_reset();
      wr(12'h60C, 32'hFFFF_FFFF);
      rd_chk("R12 masked", 12'h60C, 32'h7FFF_FFFF);
      wr(12'h608, 32'h3C);
      set_t(31'h7FFF_FFFF);
      check("R12 top match", {31'h0, ch_out[0]}, 32'h1);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule